// File: doc/BRIEF.md
# Memory Card Read Cycle Sequencer

This block is a host-side sequencer for read cycles to a removable memory card. The card has two address spaces: attribute memory and common memory. A host asks for a read by raising `req_valid` with an address and a space select. When the block can start, it acknowledges in the same cycle. The block then drives the card's address, chip enable, output enable and space-select lines with the required setup, access and hold intervals. It captures the card's data bus and returns the result with a one-cycle done pulse.

Every interval is given as a time in nanoseconds and turned into a count of clock cycles when the block is elaborated. Attribute and common space have separate access times. An attribute cycle also has a minimum time from one address change to the next. Common-space reads can be stretched by the card through an active-low wait line. That stretch has an upper bound; a standard or extended limit is chosen by a parameter. A read whose wait line stays asserted past the bound is ended and reported with a timeout flag.

The numbers in the requirements assume the default parameters: an 8 ns clock, 30 ns address setup, 150 ns attribute access, 125 ns common access, 20 ns hold, 35 ns wait-valid delay, 350 ns wait limit and 300 ns attribute cycle. Each count is the time divided by the clock period, rounded up.

Top module: `card_read_seq`

## Requirements
- R1: `req_ack` is high only while no card cycle is in progress (`card_ce_n` high) and the attribute spacing of R9 is met; a read starts on the clock edge where `req_valid` and `req_ack` are both high. After a common-space read whose output enable was low for L cycles, the earliest next start is L+8 edges after the previous start.
- R2: On the start edge, `card_addr` takes `req_addr` and `card_ce_n` goes low. `card_oe_n` stays high for 4 cycles after the address changes. `card_oe_n` is never low while `card_ce_n` is high.
- R3: `card_reg_n` takes `req_space` on the start edge: 0 selects attribute space and 1 selects common space. It stays stable while `card_ce_n` is low.
- R4: In an attribute read, `card_oe_n` is low for exactly 19 cycles and `card_wait_n` has no effect. The data bus is captured on the edge that raises `card_oe_n`. That value appears on `rsp_data` together with a one-cycle `rsp_done` pulse in the first cycle with `card_oe_n` high again.
- R5: In a common read with `card_wait_n` held high, `card_oe_n` is low for exactly 16 cycles and the captured data is returned as in R4.
- R6: In common space, `card_wait_n` is looked at only from the 5th edge after `card_oe_n` falls. If it is sampled low at the 16th edge, the read ends on the first later edge that samples it high. The data bus is captured on that same edge. A wait assertion that ends before the 16th edge does not lengthen the read.
- R7: Sampled lows of `card_wait_n` are counted from the 5th edge on. If a count of 44 is reached (375 when `EXT_WAIT` is set), the read ends on that edge, which makes `card_oe_n` low for 48 cycles. `rsp_done` then pulses with `rsp_timeout` high and `rsp_data` zero. A release sampled on that same edge completes the read normally.
- R8: After `card_oe_n` rises, `card_addr` and the low `card_ce_n` are held for 3 more cycles. `card_ce_n` is then high for at least one cycle before it falls again.
- R9: After an attribute read, the next start is no earlier than 38 edges after the previous start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host read request |
| req_space | input | 1 | 0 attribute space, 1 common space |
| req_addr | input | ADDR_W | Card address for the read |
| req_ack | output | 1 | Request is taken on this cycle's edge when `req_valid` is high |
| rsp_done | output | 1 | One-cycle pulse when a read ends |
| rsp_timeout | output | 1 | With `rsp_done`: read ended by the wait-width limit |
| rsp_data | output | DATA_W | Captured card data (zero after a timeout) |
| card_addr | output | ADDR_W | Address to the card |
| card_ce_n | output | 1 | Card chip enable, active low |
| card_oe_n | output | 1 | Card output enable, active low |
| card_reg_n | output | 1 | Space select: low attribute, high common |
| card_data_in | input | DATA_W | Card data bus |
| card_wait_n | input | 1 | Card wait request, active low |

## Verification
Two things can decide the end of a common read on the same edge: the wait counter reaching its limit, and the card releasing its wait line. A behavioural card model holds the wait line low for a chosen number of cycles. Runs of 47 and 48 cycles put the release and the limit on the same final counted edge. The scoreboard expects captured data in the first run and a timeout with zero data in the second, each with an output-enable low time of 48 cycles. A second collision is the attribute spacing expiring while a request is already waiting. Back-to-back requests check that the start lands on exactly the 38th edge.

// File: rtl/card_read_pkg.sv
`timescale 1ns/1ps
package card_read_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_STROBE = 2'd2,
      ST_RECOV  = 2'd3
   } crs_state_t;

   localparam logic SPACE_ATTR = 1'b0;
   localparam logic SPACE_COMM = 1'b1;

   // time to clock cycles, rounded up, never below one
   function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
      int unsigned c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      if (c == 0) c = 1;
      return c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/crs_profile.sv
`timescale 1ns/1ps
module crs_profile
   import card_read_pkg::*;
#(
   parameter int unsigned CLK_NS          = 8,
   parameter int unsigned T_SETUP_NS      = 30,
   parameter int unsigned T_ATTR_ACC_NS   = 150,
   parameter int unsigned T_COMM_ACC_NS   = 125,
   parameter int unsigned T_HOLD_NS       = 20,
   parameter int unsigned T_WAIT_VALID_NS = 35,
   parameter int unsigned T_WAIT_STD_NS   = 350,
   parameter int unsigned T_WAIT_EXT_NS   = 3000,
   parameter int unsigned T_ATTR_CYC_NS   = 300,
   parameter bit          EXT_WAIT        = 1'b0,
   parameter int unsigned CW              = 10
)(
   input  logic          space,
   output logic [CW-1:0] setup_m1,
   output logic [CW-1:0] acc_m1,
   output logic [CW-1:0] hold_m1,
   output logic [CW-1:0] wvalid_m1,
   output logic [CW-1:0] wait_lim_m1,
   output logic [CW-1:0] cyc_m1
);
   localparam int unsigned SETUP_C = ns_to_cyc(T_SETUP_NS, CLK_NS);
   localparam int unsigned ATTR_C  = ns_to_cyc(T_ATTR_ACC_NS, CLK_NS);
   localparam int unsigned COMM_C  = ns_to_cyc(T_COMM_ACC_NS, CLK_NS);
   localparam int unsigned HOLD_C  = ns_to_cyc(T_HOLD_NS, CLK_NS);
   localparam int unsigned WV_C    = ns_to_cyc(T_WAIT_VALID_NS, CLK_NS);
   localparam int unsigned WSTD_C  = ns_to_cyc(T_WAIT_STD_NS, CLK_NS);
   localparam int unsigned WEXT_C  = ns_to_cyc(T_WAIT_EXT_NS, CLK_NS);
   localparam int unsigned CYC_C   = ns_to_cyc(T_ATTR_CYC_NS, CLK_NS);

   initial begin
      assert (CLK_NS > 0) else $error("crs_profile: CLK_NS must be positive");
      assert (CW >= $clog2(max2(WEXT_C, CYC_C) + 2)) else $error("crs_profile: CW too narrow");
   end

   assign setup_m1  = CW'(SETUP_C - 1);
   assign hold_m1   = CW'(HOLD_C - 1);
   assign wvalid_m1 = CW'(WV_C - 1);
   assign cyc_m1    = CW'(CYC_C - 1);
   assign acc_m1    = (space == SPACE_COMM) ? CW'(COMM_C - 1) : CW'(ATTR_C - 1);

   generate
      if (EXT_WAIT) begin : g_wait_ext
         assign wait_lim_m1 = CW'(WEXT_C - 1);
      end else begin : g_wait_std
         assign wait_lim_m1 = CW'(WSTD_C - 1);
      end
   endgenerate

endmodule

// File: rtl/crs_interval.sv
`timescale 1ns/1ps
module crs_interval #(
   parameter int unsigned CW = 10
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   output logic [CW-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count <= '0;
      else if (clear)          count <= '0;
      else if (count != '1)    count <= count + 1'b1;
   end
endmodule

// File: rtl/crs_wait_mon.sv
`timescale 1ns/1ps
module crs_wait_mon #(
   parameter int unsigned CW = 10
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          window,
   input  logic          wait_low,
   input  logic [CW-1:0] lim_m1,
   output logic          expire
);
   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        low_cnt <= '0;
      else if (start)                                    low_cnt <= '0;
      else if (window && wait_low && low_cnt != lim_m1)  low_cnt <= low_cnt + 1'b1;
   end

   assign expire = window && wait_low && (low_cnt == lim_m1);

   // R7: the low-sample count never passes the configured limit
   p_wait_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      low_cnt <= lim_m1);

endmodule

// File: rtl/card_read_seq.sv
`timescale 1ns/1ps
module card_read_seq
   import card_read_pkg::*;
#(
   parameter int unsigned ADDR_W          = 12,
   parameter int unsigned DATA_W          = 16,
   parameter int unsigned CLK_NS          = 8,
   parameter int unsigned T_SETUP_NS      = 30,
   parameter int unsigned T_ATTR_ACC_NS   = 150,
   parameter int unsigned T_COMM_ACC_NS   = 125,
   parameter int unsigned T_HOLD_NS       = 20,
   parameter int unsigned T_WAIT_VALID_NS = 35,
   parameter int unsigned T_WAIT_STD_NS   = 350,
   parameter int unsigned T_WAIT_EXT_NS   = 3000,
   parameter int unsigned T_ATTR_CYC_NS   = 300,
   parameter bit          EXT_WAIT        = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_space,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ack,
   output logic              rsp_done,
   output logic              rsp_timeout,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] card_addr,
   output logic              card_ce_n,
   output logic              card_oe_n,
   output logic              card_reg_n,
   input  logic [DATA_W-1:0] card_data_in,
   input  logic              card_wait_n
);
   localparam int unsigned LONGEST =
      max2(max2(ns_to_cyc(T_WAIT_EXT_NS, CLK_NS), ns_to_cyc(T_WAIT_STD_NS, CLK_NS))
           + ns_to_cyc(T_WAIT_VALID_NS, CLK_NS),
           max2(ns_to_cyc(T_ATTR_CYC_NS, CLK_NS),
                max2(ns_to_cyc(T_ATTR_ACC_NS, CLK_NS), ns_to_cyc(T_COMM_ACC_NS, CLK_NS))));
   localparam int unsigned CW = $clog2(LONGEST + 2) + 1;

   initial begin
      assert (ADDR_W > 0 && DATA_W > 0) else $error("card_read_seq: zero bus width");
      assert (CLK_NS > 0) else $error("card_read_seq: CLK_NS must be positive");
   end

   crs_state_t    state_q, state_d;
   logic [CW-1:0] tmr, since;
   logic [CW-1:0] setup_m1, acc_m1, hold_m1, wvalid_m1, wait_lim_m1, cyc_m1;
   logic          last_attr_q;
   logic          accept, in_window, capture, expire;

   crs_profile #(
      .CLK_NS(CLK_NS), .T_SETUP_NS(T_SETUP_NS), .T_ATTR_ACC_NS(T_ATTR_ACC_NS),
      .T_COMM_ACC_NS(T_COMM_ACC_NS), .T_HOLD_NS(T_HOLD_NS),
      .T_WAIT_VALID_NS(T_WAIT_VALID_NS), .T_WAIT_STD_NS(T_WAIT_STD_NS),
      .T_WAIT_EXT_NS(T_WAIT_EXT_NS), .T_ATTR_CYC_NS(T_ATTR_CYC_NS),
      .EXT_WAIT(EXT_WAIT), .CW(CW)
   ) u_profile (
      .space(card_reg_n), .setup_m1(setup_m1), .acc_m1(acc_m1), .hold_m1(hold_m1),
      .wvalid_m1(wvalid_m1), .wait_lim_m1(wait_lim_m1), .cyc_m1(cyc_m1)
   );

   // phase timer: restarts on every state change
   crs_interval #(.CW(CW)) u_phase_tmr (
      .clk(clk), .rst_n(rst_n), .clear(state_d != state_q), .count(tmr)
   );

   // spacing timer: restarts on every accepted request
   crs_interval #(.CW(CW)) u_gap_tmr (
      .clk(clk), .rst_n(rst_n), .clear(accept), .count(since)
   );

   assign req_ack   = (state_q == ST_IDLE) && (!last_attr_q || since >= cyc_m1);
   assign accept    = req_valid && req_ack;
   assign in_window = (state_q == ST_STROBE) && (card_reg_n == SPACE_COMM) && (tmr >= wvalid_m1);
   assign capture   = (state_q == ST_STROBE) && (tmr >= acc_m1) &&
                      ((card_reg_n == SPACE_ATTR) || (in_window && card_wait_n));

   crs_wait_mon #(.CW(CW)) u_wait_mon (
      .clk(clk), .rst_n(rst_n), .start(accept), .window(in_window),
      .wait_low(!card_wait_n), .lim_m1(wait_lim_m1), .expire(expire)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (accept)                state_d = ST_SETUP;
         ST_SETUP:  if (tmr >= setup_m1)       state_d = ST_STROBE;
         ST_STROBE: if (capture || expire)     state_d = ST_RECOV;
         ST_RECOV:  if (tmr >= hold_m1)        state_d = ST_IDLE;
         default:                              state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         last_attr_q <= 1'b0;
         card_addr   <= '0;
         card_reg_n  <= 1'b1;
         rsp_done    <= 1'b0;
         rsp_timeout <= 1'b0;
         rsp_data    <= '0;
      end else begin
         state_q     <= state_d;
         rsp_done    <= capture || expire;
         rsp_timeout <= expire;
         if (accept) begin
            card_addr   <= req_addr;
            card_reg_n  <= req_space;
            last_attr_q <= (req_space == SPACE_ATTR);
         end
         if (capture)     rsp_data <= card_data_in;
         else if (expire) rsp_data <= '0;
      end
   end

   assign card_ce_n = (state_q == ST_IDLE);
   assign card_oe_n = (state_q != ST_STROBE);

   // R1: acknowledge only with the card deselected
   p_ack_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> card_ce_n);

   // R2: output enable only inside chip enable
   p_oe_inside_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !card_oe_n |-> !card_ce_n);

   // R3: space line stable through the cycle
   p_reg_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!card_ce_n && !$past(card_ce_n)) |-> $stable(card_reg_n));

   // R8: address held while the card stays enabled
   p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!card_ce_n && !$past(card_ce_n)) |-> $stable(card_addr));

   // R4: done is a single-cycle pulse, raised as output enable ends
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   p_done_on_oe_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_oe_n) |-> rsp_done);

   // R7: timeout flag only travels with done
   p_timeout_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_timeout |-> rsp_done);

endmodule

// File: tb/card_read_seq_bench.sv
`timescale 1ns/1ps
module card_read_seq_bench;
   localparam int AW       = 12;
   localparam int DW       = 16;
   localparam int CLK_NS   = 8;
   localparam int SU       = (30  + CLK_NS - 1) / CLK_NS;
   localparam int ATTR_ACC = (150 + CLK_NS - 1) / CLK_NS;
   localparam int COMM_ACC = (125 + CLK_NS - 1) / CLK_NS;
   localparam int HOLD     = (20  + CLK_NS - 1) / CLK_NS;
   localparam int WV       = (35  + CLK_NS - 1) / CLK_NS;
   localparam int WMAX     = (350 + CLK_NS - 1) / CLK_NS;
   localparam int CYC      = (300 + CLK_NS - 1) / CLK_NS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_space = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_ack, rsp_done, rsp_timeout;
   logic [DW-1:0] rsp_data;
   logic [AW-1:0] card_addr;
   logic          card_ce_n, card_oe_n, card_reg_n;
   logic [DW-1:0] card_data_in = 16'hDEAD;
   logic          card_wait_n = 1'b1;

   card_read_seq u_card_read_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
      .req_addr(req_addr), .req_ack(req_ack), .rsp_done(rsp_done),
      .rsp_timeout(rsp_timeout), .rsp_data(rsp_data), .card_addr(card_addr),
      .card_ce_n(card_ce_n), .card_oe_n(card_oe_n), .card_reg_n(card_reg_n),
      .card_data_in(card_data_in), .card_wait_n(card_wait_n)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct packed { logic [DW-1:0] data; logic tmo; logic [15:0] len; } exp_t;
   typedef struct packed { logic sp; logic [AW-1:0] a; logic [15:0] w; } job_t;
   exp_t  sb[$];
   string sb_tag[$];
   job_t  jobs[$];

   task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   function automatic logic [DW-1:0] pat(input logic sp, input logic [AW-1:0] a);
      return {sp, 3'b101, a};
   endfunction

   // behavioural card model and scoreboard monitor
   int            oe_low = 0, hold_cnt = 0, ce_high = 100, addr_age = 0, last_len = 0;
   logic          prev_oe = 1'b1, prev_ce = 1'b1, seen_strobe = 1'b0;
   logic [AW-1:0] prev_addr = '0;
   job_t          cur = '0;
   exp_t          e;
   string         t;

   always @(negedge clk) begin
      if (rst_n) begin
         if (card_addr == prev_addr) addr_age++; else addr_age = 1;
         prev_addr = card_addr;
         if (card_ce_n) ce_high++;
         if (!card_ce_n && prev_ce) begin
            check(ce_high >= 1, "R8", "CE# high gap before cycle", ce_high, 1);
            check(req_ack == 1'b0, "R1", "ack while card busy", int'(req_ack), 0);
            ce_high = 0;
         end
         if (!card_oe_n) begin
            if (prev_oe) begin
               oe_low = 1;
               seen_strobe = 1'b1;
               hold_cnt = 0;
               if (jobs.size() > 0) cur = jobs.pop_front();
               else check(1'b0, "R2", "OE# without request", 1, 0);
               check(addr_age - 1 >= SU, "R2", "address setup cycles", addr_age - 1, SU);
               check(card_addr == cur.a, "R2", "card address", int'(card_addr), int'(cur.a));
               check(card_reg_n == cur.sp, "R3", "space line", int'(card_reg_n), int'(cur.sp));
            end else oe_low++;
         end else begin
            if (!prev_oe) last_len = oe_low;
            if (!card_ce_n && seen_strobe) hold_cnt++;
         end
         if (card_ce_n && !prev_ce && seen_strobe) begin
            check(hold_cnt >= HOLD, "R8", "CE#/address hold cycles", hold_cnt, HOLD);
            seen_strobe = 1'b0;
         end
         // card outputs for the next edge
         if (!card_oe_n && oe_low >= (cur.sp ? COMM_ACC : ATTR_ACC)) card_data_in = pat(cur.sp, cur.a);
         else card_data_in = 16'hDEAD;
         card_wait_n = !(!card_oe_n && oe_low <= int'(cur.w));
         // scoreboard
         if (rsp_done) begin
            if (sb.size() == 0) check(1'b0, "R4", "unexpected done", 1, 0);
            else begin
               e = sb.pop_front();
               t = sb_tag.pop_front();
               check(rsp_data == e.data, t, "read data", int'(rsp_data), int'(e.data));
               check(rsp_timeout == e.tmo, "R7", "timeout flag", int'(rsp_timeout), int'(e.tmo));
               check(last_len == int'(e.len), t, "OE# low cycles", last_len, int'(e.len));
            end
         end
         prev_oe = card_oe_n;
         prev_ce = card_ce_n;
      end
   end

   int last_acc = 0, last_gap = 0;

   task automatic issue(input logic sp, input logic [AW-1:0] a, input int w, input bit chained, input string tag);
      exp_t ex;
      job_t j;
      int   len, acc;
      if (!sp) begin
         len = ATTR_ACC;
         ex  = '{data: pat(sp, a), tmo: 1'b0, len: 16'(len)};
      end else if (w >= WV - 1 + WMAX) begin
         len = WV - 1 + WMAX;
         ex  = '{data: '0, tmo: 1'b1, len: 16'(len)};
      end else begin
         len = (w + 1 > COMM_ACC) ? w + 1 : COMM_ACC;
         ex  = '{data: pat(sp, a), tmo: 1'b0, len: 16'(len)};
      end
      j = '{sp: sp, a: a, w: 16'(w)};
      sb.push_back(ex);
      sb_tag.push_back(tag);
      jobs.push_back(j);
      @(negedge clk);
      req_valid = 1'b1;
      req_space = sp;
      req_addr  = a;
      while (!req_ack) @(negedge clk);
      acc = cyc;
      if (chained)
         check(acc - last_acc == last_gap, (last_gap == CYC) ? "R9" : "R1", "start spacing", acc - last_acc, last_gap);
      last_acc = acc;
      last_gap = sp ? (len + SU + HOLD + 1) : ((CYC > len + SU + HOLD + 1) ? CYC : len + SU + HOLD + 1);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(card_ce_n == 1'b1, "R2", "reset CE#", int'(card_ce_n), 1);
      check(card_oe_n == 1'b1, "R2", "reset OE#", int'(card_oe_n), 1);
      check(rsp_done == 1'b0, "R4", "reset done", int'(rsp_done), 0);
      check(req_ack == 1'b1, "R1", "reset ack", int'(req_ack), 1);

      issue(1'b0, 12'h123, 0,   1'b0, "R4");   // plain attribute read
      issue(1'b0, 12'hABC, 30,  1'b1, "R4");   // WAIT# ignored in attribute space; R9 spacing
      issue(1'b1, 12'h055, 0,   1'b1, "R5");   // common, no wait
      issue(1'b1, 12'h3C3, 10,  1'b1, "R6");   // early wait only
      issue(1'b1, 12'h7F0, 25,  1'b1, "R6");   // stretched by wait
      issue(1'b1, 12'h0F1, 47,  1'b1, "R7");   // release on last counted edge
      issue(1'b1, 12'h0F2, 48,  1'b1, "R7");   // limit reached on same edge
      issue(1'b1, 12'h0F3, 200, 1'b1, "R7");   // stuck wait
      issue(1'b0, 12'h444, 0,   1'b1, "R4");   // attribute after common
      issue(1'b0, 12'h445, 0,   1'b1, "R9");   // back-to-back attribute
      issue(1'b1, 12'h446, 0,   1'b1, "R5");
      for (int i = 0; i < 6; i++)
         issue(1'b1, AW'($urandom_range(0, 4095)), int'($urandom_range(0, 60)), 1'b1, "R6");
      while (sb.size() != 0) @(negedge clk);
      repeat (10) @(negedge clk);
      finish_run();
   end

endmodule